// File: doc/BRIEF.md
# Wrapping Sample Ring Buffer

This block is a circular buffer that sits between a sample producer, such as an analog-to-digital converter, and a host that drains it. Each accepted producer sample goes into the slot at the front index, and the front index then moves on by one. The host reads samples straight out of a data window at any slot it chooses. It then tells the block how far it has drained by writing a new rear index. Because the depth need not be a power of two, the front index wraps by comparing against the last slot and returning to zero.

An eight-bit event flag register collects the fill-threshold indication, producer overflow, a converter fault and five events from nearby logic. A mask register selects which flags drive the single interrupt output. The trip point of the fill threshold is held in a register that resets to half the depth. The host computes the number of waiting samples as the front index minus the rear index, adding the depth when the difference is negative. One slot always stays unused, so equal indices mean the buffer is empty.

Top module: `sring_top`

## Requirements
- R1: After reset the front index, rear index, mask and flags read 0, the threshold reads DEPTH/2 rounded down (1001 by default), and irq is low.
- R2: A producer sample offered while the buffer is not full is stored at the front index, and front advances by one. From DEPTH-1 it wraps to 0.
- R3: A host read with h_rd high returns its data on h_rdata one cycle later. Addresses 0 to DEPTH-1 return the stored sample. Registers sit at offsets from base 2^AW-8: +0 front (read only), +1 rear, +2 mask, +3 flags, +4 threshold. Any other address returns 0.
- R4: The fill level is front minus rear, plus DEPTH when the difference is negative. The buffer is full at DEPTH-1 entries. A sample offered while full is dropped, front is left unchanged, and flag bit 1 (producer overflow) is set.
- R5: Flag bit 0 (fill threshold) rises one cycle after the level reaches the threshold. It falls one cycle after a rear write brings the level below the threshold. Host writes to bit 0 have no effect.
- R6: Flag bits 1 to 7 are sticky and are cleared by writing 1 to them. Bit 2 is set by ad_hw_err. Bits 3 to 7 are set by aux_evt[0] to aux_evt[4]. A set event in the same cycle as a clear of that bit leaves the bit set.
- R7: irq is high exactly when some flag bit and the matching mask bit are both 1. A mask of 0 holds irq low.
- R8: A host write to the rear register with a value of DEPTH or more is ignored.
- R9: Writing the threshold register moves the level at which bit 0 rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prod_valid | input | 1 | Producer offers a sample this cycle |
| prod_data | input | DW | Producer sample |
| ad_hw_err | input | 1 | Converter fault pulse, sets flag bit 2 |
| aux_evt | input | 5 | Event pulses, set flag bits 3 to 7 |
| h_wr | input | 1 | Host register write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | AW | Host address |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Host read data, one cycle after h_rd |
| irq | output | 1 | Masked interrupt |

## Verification
Two things can land on the overflow flag in the same cycle: a dropped producer sample sets it, while a host write-one-to-clear tries to clear it. The bench fills the buffer to capacity. It then offers one more sample in the very cycle that it writes 1 to bit 1 of the flags register. The bench expects bit 1 to read back as set and the front index to be unchanged. A second clear on its own must then bring bit 1 back to 0.

// File: rtl/sring_pkg.sv
package sring_pkg;
   localparam int NF = 8;           // flag register width
   localparam int NAUX = NF - 3;    // auxiliary event inputs
   // flag bit positions
   localparam int FB_LVL  = 0;
   localparam int FB_OVF  = 1;
   localparam int FB_HWE  = 2;
   localparam int FB_AUX0 = 3;
   // register offsets from the top of the host address space
   localparam int RO_FRONT = 0;
   localparam int RO_REAR  = 1;
   localparam int RO_MASK  = 2;
   localparam int RO_FLAGS = 3;
   localparam int RO_THR   = 4;
   localparam int REG_SPAN = 8;
endpackage

// File: rtl/sring_idx.sv
module sring_idx #(
   parameter int DEPTH = 2003,
   parameter int IW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [IW-1:0] idx
);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);
   logic [IW-1:0] nxt;

   generate
      if (POW2) begin : g_natural
         assign nxt = idx + 1'b1;
      end else begin : g_compare
         localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);
         assign nxt = (idx == LAST) ? '0 : idx + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   idx <= '0;
      else if (adv) idx <= nxt;
   end
endmodule

// File: rtl/sring_level.sv
module sring_level #(
   parameter int DEPTH = 2003,
   parameter int IW    = $clog2(DEPTH)
) (
   input  logic [IW-1:0] front,
   input  logic [IW-1:0] rear,
   output logic [IW:0]   lvl
);
   localparam logic [IW:0] DEP = (IW+1)'(DEPTH);
   logic [IW:0] f, r;

   always_comb begin
      f = {1'b0, front};
      r = {1'b0, rear};
      if (f >= r) lvl = f - r;
      else        lvl = f + DEP - r;
   end
endmodule

// File: rtl/sring_flags.sv
module sring_flags #(
   parameter int NF = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lvl_hit,
   input  logic [NF-1:1] set_ev,
   input  logic          clr_we,
   input  logic [NF-1:1] clr_bits,
   input  logic [NF-1:0] mask,
   output logic [NF-1:0] flags,
   output logic          irq
);
   logic [NF-1:0] nxt;

   always_comb begin
      nxt[0] = lvl_hit;
      for (int i = 1; i < NF; i++)
         nxt[i] = set_ev[i] | (flags[i] & ~(clr_we & clr_bits[i]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= nxt;
   end

   assign irq = |(flags & mask);
endmodule

// File: rtl/sring_top.sv
module sring_top
   import sring_pkg::*;
#(
   parameter int DEPTH = 2003,
   parameter int DW    = 16,
   parameter int AW    = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            prod_valid,
   input  logic [DW-1:0]   prod_data,
   input  logic            ad_hw_err,
   input  logic [NAUX-1:0] aux_evt,
   input  logic            h_wr,
   input  logic            h_rd,
   input  logic [AW-1:0]   h_addr,
   input  logic [DW-1:0]   h_wdata,
   output logic [DW-1:0]   h_rdata,
   output logic            irq
);
   localparam int IW = $clog2(DEPTH);
   localparam int LW = IW + 1;
   localparam int RB = (1 << AW) - REG_SPAN;
   localparam logic [AW-1:0] A_FRONT = AW'(RB + RO_FRONT);
   localparam logic [AW-1:0] A_REAR  = AW'(RB + RO_REAR);
   localparam logic [AW-1:0] A_MASK  = AW'(RB + RO_MASK);
   localparam logic [AW-1:0] A_FLAGS = AW'(RB + RO_FLAGS);
   localparam logic [AW-1:0] A_THR   = AW'(RB + RO_THR);
   localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH - 1);
   localparam logic [LW-1:0] THR_RST  = LW'(DEPTH / 2);

   generate
      if (DEPTH < 4) begin : g_chk_depth
         $error("sring_top: DEPTH must be at least 4");
      end
      if (DEPTH > RB) begin : g_chk_space
         $error("sring_top: data window overlaps register space");
      end
      if (DW < LW || DW < NF) begin : g_chk_dw
         $error("sring_top: DW too narrow for indices or flags");
      end
   endgenerate

   logic [IW-1:0] front_q, rear_q;
   logic [LW-1:0] lvl, thr_q;
   logic [NF-1:0] mask_q, flags_q;
   logic          push_ok, full;
   logic          rear_we, mask_we, thr_we, flg_we;
   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] reg_mux;

   assign full    = (lvl == FULL_LVL);
   assign push_ok = prod_valid & ~full;

   sring_idx #(.DEPTH(DEPTH), .IW(IW)) front_i (
      .clk(clk), .rst_n(rst_n), .adv(push_ok), .idx(front_q));

   sring_level #(.DEPTH(DEPTH), .IW(IW)) level_i (
      .front(front_q), .rear(rear_q), .lvl(lvl));

   always_ff @(posedge clk) begin
      if (push_ok) mem[front_q] <= prod_data;
   end

   assign rear_we = h_wr && (h_addr == A_REAR) && (h_wdata < DW'(DEPTH));
   assign mask_we = h_wr && (h_addr == A_MASK);
   assign thr_we  = h_wr && (h_addr == A_THR);
   assign flg_we  = h_wr && (h_addr == A_FLAGS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rear_q <= '0;
         mask_q <= '0;
         thr_q  <= THR_RST;
      end else begin
         if (rear_we) rear_q <= h_wdata[IW-1:0];
         if (mask_we) mask_q <= h_wdata[NF-1:0];
         if (thr_we)  thr_q  <= h_wdata[LW-1:0];
      end
   end

   sring_flags #(.NF(NF)) flags_i (
      .clk(clk), .rst_n(rst_n),
      .lvl_hit(lvl >= thr_q),
      .set_ev({aux_evt, ad_hw_err, prod_valid & full}),
      .clr_we(flg_we),
      .clr_bits(h_wdata[NF-1:1]),
      .mask(mask_q),
      .flags(flags_q),
      .irq(irq));

   always_comb begin
      case (h_addr)
         A_FRONT: reg_mux = DW'(front_q);
         A_REAR:  reg_mux = DW'(rear_q);
         A_MASK:  reg_mux = DW'(mask_q);
         A_FLAGS: reg_mux = DW'(flags_q);
         A_THR:   reg_mux = DW'(thr_q);
         default: reg_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) h_rdata <= '0;
      else if (h_rd) begin
         if (h_addr < AW'(DEPTH)) h_rdata <= mem[h_addr[IW-1:0]];
         else                     h_rdata <= reg_mux;
      end
   end
endmodule

// File: rtl/sring_chk.sv
module sring_chk
   import sring_pkg::*;
#(
   parameter int DEPTH = 2003,
   parameter int DW    = 16,
   parameter int AW    = 12,
   parameter int IW    = $clog2(DEPTH)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          prod_valid,
   input logic          h_wr,
   input logic [AW-1:0] h_addr,
   input logic [DW-1:0] h_wdata,
   input logic [IW-1:0] front,
   input logic [IW-1:0] rear,
   input logic [IW:0]   lvl,
   input logic [NF-1:0] flags,
   input logic [NF-1:0] mask,
   input logic          irq
);
   localparam logic [AW-1:0] A_FLG = AW'((1 << AW) - REG_SPAN + RO_FLAGS);
   localparam logic [IW:0]   FULLV = (IW+1)'(DEPTH - 1);
   localparam logic [IW-1:0] LASTI = IW'(DEPTH - 1);

   // R2
   front_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      front <= LASTI);

   // R2
   advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prod_valid && lvl != FULLV) |=>
      front == (($past(front) == LASTI) ? '0 : $past(front) + 1'b1));

   // R4
   overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prod_valid && lvl == FULLV) |=> ($stable(front) && flags[FB_OVF]));

   // R6
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[FB_OVF] && !(h_wr && h_addr == A_FLG && h_wdata[FB_OVF])) |=> flags[FB_OVF]);

   // R7
   mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> !irq);

   // R8
   rear_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rear <= LASTI);
endmodule

bind sring_top sring_chk #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) chk_i (
   .clk(clk), .rst_n(rst_n), .prod_valid(prod_valid), .h_wr(h_wr),
   .h_addr(h_addr), .h_wdata(h_wdata), .front(front_q), .rear(rear_q),
   .lvl(lvl), .flags(flags_q), .mask(mask_q), .irq(irq));

// File: tb/sring_top_tb_top.sv
`timescale 1ns/1ps
module sring_top_tb_top;
   localparam int DEPTH = 2003;
   localparam int DW = 16;
   localparam int AW = 12;
   localparam int RB = (1 << AW) - 8;
   localparam int A_FRONT = RB, A_REAR = RB + 1, A_MASK = RB + 2;
   localparam int A_FLAGS = RB + 3, A_THR = RB + 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic prod_valid = 1'b0, ad_hw_err = 1'b0, h_wr = 1'b0, h_rd = 1'b0;
   logic [DW-1:0] prod_data = '0, h_wdata = '0;
   logic [4:0] aux_evt = '0;
   logic [AW-1:0] h_addr = '0;
   logic [DW-1:0] h_rdata;
   logic irq;
   int checks = 0, errors = 0;

   always #4 clk = ~clk;

   sring_top #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .prod_valid(prod_valid), .prod_data(prod_data),
      .ad_hw_err(ad_hw_err), .aux_evt(aux_evt), .h_wr(h_wr), .h_rd(h_rd),
      .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata), .irq(irq));

   function automatic logic [DW-1:0] pat(int i);
      return DW'(i * 7 + 16'h3c1);
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; prod_valid = 1'b0; h_wr = 1'b0; h_rd = 1'b0;
      ad_hw_err = 1'b0; aux_evt = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic push_n(int n, int base);
      for (int i = 0; i < n; i++) begin
         prod_valid = 1'b1; prod_data = pat(base + i);
         @(negedge clk);
      end
      prod_valid = 1'b0;
   endtask

   task automatic host_wr(int a, int d);
      h_wr = 1'b1; h_addr = AW'(a); h_wdata = DW'(d);
      @(negedge clk);
      h_wr = 1'b0;
   endtask

   task automatic host_rd(int a, output int d);
      h_rd = 1'b1; h_addr = AW'(a);
      @(negedge clk);
      h_rd = 1'b0;
      d = int'(h_rdata);
   endtask

   task automatic t_reset();
      int d;
      do_reset();
      host_rd(A_FRONT, d); chk("R1 front", d, 0);
      host_rd(A_REAR, d);  chk("R1 rear", d, 0);
      host_rd(A_MASK, d);  chk("R1 mask", d, 0);
      host_rd(A_FLAGS, d); chk("R1 flags", d, 0);
      host_rd(A_THR, d);   chk("R1 threshold", d, 1001);
      chk("R1 irq", int'(irq), 0);
   endtask

   task automatic t_push_read();
      int d;
      do_reset();
      push_n(5, 100);
      host_rd(A_FRONT, d); chk("R2 front after 5", d, 5);
      for (int i = 0; i < 5; i++) begin
         host_rd(i, d); chk("R3 data", d, int'(pat(100 + i)));
      end
      host_rd(RB + 6, d); chk("R3 unmapped", d, 0);
   endtask

   task automatic t_threshold();
      int d;
      do_reset();
      host_wr(A_MASK, 1);
      push_n(1000, 0);
      @(negedge clk);
      chk("R5 below threshold irq", int'(irq), 0);
      host_rd(A_FLAGS, d); chk("R5 below threshold flag", d, 0);
      push_n(1, 1000);
      chk("R5 one-cycle lag", int'(irq), 0);
      @(negedge clk);
      chk("R7 irq at threshold", int'(irq), 1);
      host_rd(A_FLAGS, d); chk("R5 flag at threshold", d, 1);
      host_wr(A_FLAGS, 1);
      host_rd(A_FLAGS, d); chk("R5 write to bit0 ignored", d, 1);
      host_wr(A_REAR, 1);
      @(negedge clk);
      chk("R5 cleared after rear write", int'(irq), 0);
   endtask

   task automatic t_full_wrap();
      int d;
      do_reset();
      push_n(2002, 0);
      host_rd(A_FRONT, d); chk("R4 front at full", d, 2002);
      // overflow sample in the same cycle as a clear of bit 1
      prod_valid = 1'b1; prod_data = 16'hdead;
      h_wr = 1'b1; h_addr = AW'(A_FLAGS); h_wdata = 16'h0002;
      @(negedge clk);
      prod_valid = 1'b0; h_wr = 1'b0;
      host_rd(A_FRONT, d); chk("R4 front unchanged on overflow", d, 2002);
      host_rd(A_FLAGS, d); chk("R6 set beats clear", d, 3);
      chk("R7 masked off", int'(irq), 0);
      host_wr(A_FLAGS, 2);
      host_rd(A_FLAGS, d); chk("R6 W1C clears bit1", d, 1);
      host_wr(A_REAR, 2002);
      push_n(3, 5000);
      host_rd(A_FRONT, d); chk("R2 front wrapped", d, 2);
      host_rd(2002, d); chk("R2 data last slot", d, int'(pat(5000)));
      host_rd(0, d);    chk("R2 data slot 0", d, int'(pat(5001)));
      host_rd(1, d);    chk("R2 data slot 1", d, int'(pat(5002)));
      host_rd(3, d);    chk("R3 old data kept", d, int'(pat(3)));
      host_rd(A_FLAGS, d); chk("R5 low after drain", d, 0);
   endtask

   task automatic t_thr_prog();
      int d;
      do_reset();
      host_wr(A_THR, 3);
      host_rd(A_THR, d); chk("R9 threshold readback", d, 3);
      push_n(2, 0);
      @(negedge clk);
      host_rd(A_FLAGS, d); chk("R9 below new threshold", d, 0);
      push_n(1, 2);
      @(negedge clk);
      host_rd(A_FLAGS, d); chk("R9 at new threshold", d, 1);
   endtask

   task automatic t_events();
      int d;
      do_reset();
      ad_hw_err = 1'b1; aux_evt = 5'b10101;
      @(negedge clk);
      ad_hw_err = 1'b0; aux_evt = '0;
      repeat (2) @(negedge clk);
      host_rd(A_FLAGS, d); chk("R6 sticky events", d, 8'hac);
      chk("R7 mask zero", int'(irq), 0);
      host_wr(A_MASK, 4);
      chk("R7 mask bit2", int'(irq), 1);
      host_wr(A_FLAGS, 8'h84);
      host_rd(A_FLAGS, d); chk("R6 partial clear", d, 8'h28);
      chk("R7 irq after clear", int'(irq), 0);
   endtask

   task automatic t_rear_bad();
      int d;
      do_reset();
      push_n(10, 0);
      host_wr(A_REAR, 4);
      host_rd(A_REAR, d); chk("R8 valid rear", d, 4);
      host_wr(A_REAR, DEPTH);
      host_rd(A_REAR, d); chk("R8 out-of-range rear ignored", d, 4);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_push_read();
      t_threshold();
      t_full_wrap();
      t_thr_prog();
      t_events();
      t_rear_bad();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule